// File: doc/BRIEF.md
# Redundant Boot Flash Selector with Watchdog Failover

This block sits between a processor's single SPI boot chip-select and two serial boot flash devices holding identical firmware. It steers the chip-select to exactly one device, the active one, while the clock, the output data line and the return data line pass straight through. The device that has the chip-select also drives the processor's return data line. After a power-on reset the active device follows a manual selector switch.

A boot watchdog runs from the first clock after power-on reset. Firmware stops it by writing a fixed success code to the status register. If the code does not arrive before the programmed timeout, the block pulls the board reset low for a fixed number of clocks and swaps to the other device, so the next boot tries the other firmware copy. A small register port lets firmware enable or disable the watchdog, set its timeout in ticks, and read the switch setting, the active device and the success flag.

Top module: `bootsel_top`

## Requirements
- R1: On the first clock after power-on reset release, the active device is captured from `swBootSel`: 1 selects device 0 (flash A) and 0 selects device 1 (flash B). The status register (address 2) reads bit0 = raw `swBootSel`, bit1 = active device (0 = A, 1 = B), bit2 = boot-success flag, and 0 in the other bits.
- R2: The active flash's chip-select equals `spiCsN`. The other flash's chip-select is held high. Both are high during reset and before the capture.
- R3: `flashSclk` and `flashMosi` equal `spiSclk` and `spiMosi`. `spiMiso` equals the active device's return data line whether or not the chip-select is active.
- R4: The control register (address 0, bit0 = enable) resets to 1. The count register (address 1) resets to 10. The watchdog runs while it is enabled, no success code has been written, and no reset pulse is active. It expires N×TICK_DIV clocks after it starts running, where N = max(count, 1) and TICK_DIV defaults to 4.
- R5: On expiry, `boardRstN` goes low for exactly RST_CYCLES clocks (default 4), and the active device toggles.
- R6: Expiry restores the control and count registers to their reset values. The watchdog starts a full timeout again when the pulse ends, and a second expiry toggles the device back.
- R7: Writing 0xA4 to address 2 sets the success flag. The watchdog then never expires until the next power-on reset.
- R8: A write to address 2 with any value other than 0xA4 leaves the success flag clear, and the watchdog still expires.
- R9: Clearing the enable bit stops the watchdog and discards its progress. Setting it again starts a full timeout.
- R10: Register writes while `boardRstN` is low have no effect.
- R11: Address 3 reads 0. Writes cannot change status bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstPorN | input | 1 | Power-on reset, asynchronous, active low |
| swBootSel | input | 1 | Manual switch, 1 = prefer device 0 |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational on regAddr) |
| spiCsN | input | 1 | Processor boot chip-select, active low |
| spiSclk | input | 1 | Processor SPI clock |
| spiMosi | input | 1 | Processor SPI output data |
| spiMiso | output | 1 | Return data to the processor |
| flashACsN | output | 1 | Device 0 chip-select |
| flashBCsN | output | 1 | Device 1 chip-select |
| flashSclk | output | 1 | SPI clock to both devices |
| flashMosi | output | 1 | SPI data to both devices |
| flashAMiso | input | 1 | Device 0 return data |
| flashBMiso | input | 1 | Device 1 return data |
| boardRstN | output | 1 | Board reset pulse, active low |

## Verification
A wrong active-device bit shows at the chip-select pins in the same cycle, because the processor's chip-select lands on the wrong flash, and it also appears in status bit1. Faults in the watchdog counter or prescaler show as a `boardRstN` edge that comes a whole number of clocks early or late. The bench therefore measures the expiry time in clocks and the pulse width from known write edges. A success flag that is lost or set by mistake shows as a missing or unexpected board reset within one timeout period.

// File: rtl/bootsel_pkg.sv
package bootsel_pkg;
  typedef struct packed {
    logic swapDev;
    logic startPulse;
  } wdStrobe_t;

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_COUNT  = 1;
  localparam int ADDR_STATUS = 2;
endpackage

// File: rtl/bootsel_ctrl.sv
module bootsel_ctrl
  import bootsel_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int TICK_DIV    = 4,
  parameter int DEF_TIMEOUT = 10,
  parameter int OK_CODE     = 8'hA4
) (
  input  logic              clk,
  input  logic              rstPorN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              swBootSel,
  input  logic              activeDev,
  input  logic              devValid,
  input  logic              pulseActive,
  output wdStrobe_t         strobe
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [DATA_W-1:0] DEF_CNT  = DATA_W'(DEF_TIMEOUT);
  localparam logic [DATA_W-1:0] CODE_OK  = DATA_W'(OK_CODE);

  logic              wdEn;
  logic [DATA_W-1:0] timeoutReg;
  logic              bootOk;
  logic [PRE_W-1:0]  preCnt;
  logic [DATA_W-1:0] tickCnt;
  logic              running, tick, expire, wrOk;
  logic [DATA_W:0]   nextTicks, limit;

  assign running   = wdEn && !bootOk && !pulseActive && devValid;
  assign tick      = running && (preCnt == PRE_LAST);
  assign nextTicks = {1'b0, tickCnt} + 1'b1;
  assign limit     = (timeoutReg == '0) ? (DATA_W+1)'(1) : {1'b0, timeoutReg};
  assign expire    = tick && (nextTicks >= limit);
  assign wrOk      = regWe && !pulseActive;

  assign strobe.swapDev    = expire;
  assign strobe.startPulse = expire;

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (!running) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else begin
      preCnt <= (preCnt == PRE_LAST) ? '0 : preCnt + 1'b1;
      if (tick) tickCnt <= expire ? '0 : nextTicks[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      wdEn       <= 1'b1;
      timeoutReg <= DEF_CNT;
      bootOk     <= 1'b0;
    end else if (expire) begin
      wdEn       <= 1'b1;
      timeoutReg <= DEF_CNT;
      bootOk     <= 1'b0;
    end else if (wrOk) begin
      case (int'(regAddr))
        ADDR_CTRL:   wdEn <= regWdata[0];
        ADDR_COUNT:  timeoutReg <= regWdata;
        ADDR_STATUS: if (regWdata == CODE_OK) bootOk <= 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdata = '0;
    case (int'(regAddr))
      ADDR_CTRL:   regRdata[0] = wdEn;
      ADDR_COUNT:  regRdata = timeoutReg;
      ADDR_STATUS: begin
        regRdata[0] = swBootSel;
        regRdata[1] = activeDev;
        regRdata[2] = bootOk;
      end
      default: regRdata = '0;
    endcase
  end

  // R7: a recorded success code keeps the watchdog from firing
  p_no_expire_after_ok_r7: assert property (@(posedge clk) disable iff (!rstPorN)
    bootOk |-> !strobe.swapDev);

  // R10: writes during the board reset pulse leave the registers alone
  p_writes_blocked_r10: assert property (@(posedge clk) disable iff (!rstPorN)
    (pulseActive && regWe) |=> ($stable(wdEn) && $stable(timeoutReg) && $stable(bootOk)));
endmodule

// File: rtl/bootsel_path.sv
module bootsel_path
  import bootsel_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rstPorN,
  input  logic      swBootSel,
  input  wdStrobe_t strobe,
  input  logic      spiCsN,
  input  logic      spiSclk,
  input  logic      spiMosi,
  output logic      spiMiso,
  output logic      flashACsN,
  output logic      flashBCsN,
  output logic      flashSclk,
  output logic      flashMosi,
  input  logic      flashAMiso,
  input  logic      flashBMiso,
  output logic      activeDev,
  output logic      devValid,
  output logic      pulseActive,
  output logic      boardRstN
);
  localparam int RST_W = $clog2(RST_CYCLES + 1);
  localparam logic [RST_W-1:0] RST_LOAD = RST_W'(RST_CYCLES);

  logic [RST_W-1:0] pulseCnt;

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      devValid  <= 1'b0;
      activeDev <= 1'b0;
    end else if (!devValid) begin
      devValid  <= 1'b1;
      activeDev <= ~swBootSel;
    end else if (strobe.swapDev) begin
      activeDev <= ~activeDev;
    end
  end

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN)               pulseCnt <= '0;
    else if (strobe.startPulse) pulseCnt <= RST_LOAD;
    else if (pulseCnt != '0)    pulseCnt <= pulseCnt - 1'b1;
  end

  assign pulseActive = (pulseCnt != '0);
  assign boardRstN   = !pulseActive;

  assign flashACsN = (devValid && !activeDev) ? spiCsN : 1'b1;
  assign flashBCsN = (devValid &&  activeDev) ? spiCsN : 1'b1;
  assign flashSclk = spiSclk;
  assign flashMosi = spiMosi;
  assign spiMiso   = activeDev ? flashBMiso : flashAMiso;

  // R2: never both devices selected
  p_cs_exclusive_r2: assert property (@(posedge clk) disable iff (!rstPorN)
    !(!flashACsN && !flashBCsN));

  // R2: an idle processor select leaves both devices idle
  p_cs_idle_r2: assert property (@(posedge clk) disable iff (!rstPorN)
    spiCsN |-> (flashACsN && flashBCsN));

  // R5: expiry flips the active device
  p_swap_on_expire_r5: assert property (@(posedge clk) disable iff (!rstPorN)
    strobe.swapDev |=> (activeDev != $past(activeDev)));

  // R5: without expiry the captured device does not move
  p_dev_stable_r5: assert property (@(posedge clk) disable iff (!rstPorN)
    (devValid && !strobe.swapDev) |=> $stable(activeDev));
endmodule

// File: rtl/bootsel_top.sv
module bootsel_top
  import bootsel_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int TICK_DIV    = 4,
  parameter int DEF_TIMEOUT = 10,
  parameter int RST_CYCLES  = 4,
  parameter int OK_CODE     = 8'hA4
) (
  input  logic              clk,
  input  logic              rstPorN,
  input  logic              swBootSel,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              spiCsN,
  input  logic              spiSclk,
  input  logic              spiMosi,
  output logic              spiMiso,
  output logic              flashACsN,
  output logic              flashBCsN,
  output logic              flashSclk,
  output logic              flashMosi,
  input  logic              flashAMiso,
  input  logic              flashBMiso,
  output logic              boardRstN
);
  wdStrobe_t strobe;
  logic activeDev, devValid, pulseActive;

  bootsel_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TICK_DIV(TICK_DIV),
    .DEF_TIMEOUT(DEF_TIMEOUT), .OK_CODE(OK_CODE)
  ) uCtrl (
    .clk(clk), .rstPorN(rstPorN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .swBootSel(swBootSel),
    .activeDev(activeDev), .devValid(devValid), .pulseActive(pulseActive),
    .strobe(strobe)
  );

  bootsel_path #(.RST_CYCLES(RST_CYCLES)) uPath (
    .clk(clk), .rstPorN(rstPorN), .swBootSel(swBootSel), .strobe(strobe),
    .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .flashACsN(flashACsN), .flashBCsN(flashBCsN), .flashSclk(flashSclk),
    .flashMosi(flashMosi), .flashAMiso(flashAMiso), .flashBMiso(flashBMiso),
    .activeDev(activeDev), .devValid(devValid), .pulseActive(pulseActive),
    .boardRstN(boardRstN)
  );
endmodule

// File: tb/sim_bootsel_top.sv
module sim_bootsel_top;
  logic clk = 1'b0;
  logic rstPorN = 1'b0, swBootSel = 1'b1, regWe = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWdata = '0, regRdata;
  logic spiCsN = 1'b1, spiSclk = 1'b0, spiMosi = 1'b0, spiMiso;
  logic flashACsN, flashBCsN, flashSclk, flashMosi;
  logic flashAMiso = 1'b0, flashBMiso = 1'b0, boardRstN;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bootsel_top u0 (.*);

  // {sw, cs, sclk, mosi, misoA, misoB, expCsA, expCsB, expMiso, expSclk, expMosi}
  localparam logic [10:0] VEC [0:7] = '{
    11'b1_0_1_0_1_0_0_1_1_1_0,
    11'b1_0_0_1_0_1_0_1_0_0_1,
    11'b1_1_1_1_1_0_1_1_1_1_1,
    11'b1_0_1_1_0_0_0_1_0_1_1,
    11'b0_0_1_0_1_0_1_0_0_1_0,
    11'b0_0_0_1_0_1_1_0_1_0_1,
    11'b0_1_0_0_1_1_1_1_1_0_0,
    11'b0_0_1_1_1_0_1_0_0_1_1
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic por(input logic sw);
    rstPorN = 1'b0;
    swBootSel = sw;
    repeat (2) @(posedge clk);
    @(negedge clk) rstPorN = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(posedge clk);
    #1 regWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  // clocks until boardRstN is seen low, 0 if never within the limit
  task automatic waitRst(input int limit, output int n);
    n = 0;
    for (int k = 1; k <= limit; k++) begin
      if (n == 0) begin
        @(posedge clk);
        #1;
        if (!boardRstN) n = k;
      end
    end
  endtask

  task automatic pulseWidth(output int w);
    bit hi = 0;
    w = 1;
    while (!hi) begin
      @(posedge clk);
      #1;
      if (boardRstN) hi = 1;
      else w++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: bench hung actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n, w;

    // R2 reset state: both chip-selects idle, no board reset
    spiCsN = 1'b0;
    #5;
    chk("R2 reset csA", {7'b0, flashACsN}, 8'h1);
    chk("R2 reset csB", {7'b0, flashBCsN}, 8'h1);
    chk("R5 reset boardRstN", {7'b0, boardRstN}, 8'h1);

    // R2 R3 steering table
    for (int i = 0; i < 8; i++) begin
      por(VEC[i][10]);
      spiCsN = VEC[i][9]; spiSclk = VEC[i][8]; spiMosi = VEC[i][7];
      flashAMiso = VEC[i][6]; flashBMiso = VEC[i][5];
      #1;
      chk($sformatf("R2 row%0d csA", i), {7'b0, flashACsN}, {7'b0, VEC[i][4]});
      chk($sformatf("R2 row%0d csB", i), {7'b0, flashBCsN}, {7'b0, VEC[i][3]});
      chk($sformatf("R3 row%0d miso", i), {7'b0, spiMiso}, {7'b0, VEC[i][2]});
      chk($sformatf("R3 row%0d sclk/mosi", i), {6'b0, flashSclk, flashMosi},
          {6'b0, VEC[i][1], VEC[i][0]});
    end
    spiCsN = 1'b1;

    // R1 R4 R11 register reset values
    por(1'b1);
    rd(2'd0, d); chk("R4 ctrl reset", d, 8'h01);
    rd(2'd1, d); chk("R4 count reset", d, 8'd10);
    rd(2'd2, d); chk("R1 status sw=1", d, 8'h01);
    rd(2'd3, d); chk("R11 addr3 reads zero", d, 8'h00);
    por(1'b0);
    rd(2'd2, d); chk("R1 status sw=0", d, 8'h02);

    // R4 default expiry 40 clocks after POR, R5 pulse and swap
    por(1'b1);
    waitRst(200, n); chk("R4 default timeout clocks", 8'(n), 8'd40);
    pulseWidth(w);   chk("R5 pulse width", 8'(w), 8'd4);
    rd(2'd2, d);     chk("R5 status after swap", d, 8'h03);
    spiCsN = 1'b0; #1;
    chk("R5 csB follows after swap", {6'b0, flashACsN, flashBCsN}, 8'h2);
    spiCsN = 1'b1;

    // R4 programmed timeout, R6 restore and swap back
    por(1'b1);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd5);
    wr(2'd0, 8'h01);
    waitRst(200, n); chk("R4 count=5 timeout clocks", 8'(n), 8'd20);
    pulseWidth(w);
    rd(2'd0, d); chk("R6 ctrl restored", d, 8'h01);
    rd(2'd1, d); chk("R6 count restored", d, 8'd10);
    waitRst(200, n); chk("R6 second timeout clocks", 8'(n), 8'd39);
    pulseWidth(w);
    rd(2'd2, d); chk("R6 device back to A", d, 8'h01);

    // R8 wrong code ignored
    por(1'b1);
    wr(2'd2, 8'h55);
    rd(2'd2, d); chk("R8 wrong code flag", d, 8'h01);
    waitRst(200, n); chk("R8 still expires", {7'b0, (n > 0 && n <= 40)}, 8'h1);
    pulseWidth(w);

    // R7 R11 success code stops watchdog, status bits 0/1 kept
    por(1'b1);
    wr(2'd2, 8'hA4);
    rd(2'd2, d); chk("R7 R11 status after code", d, 8'h05);
    waitRst(400, n); chk("R7 no reset after code", 8'(n), 8'd0);
    wr(2'd2, 8'h00);
    rd(2'd2, d); chk("R11 status bits after write", d, 8'h05);

    // R9 disable stops and clears progress
    por(1'b1);
    wr(2'd0, 8'h00);
    waitRst(100, n); chk("R9 disabled no reset", 8'(n), 8'd0);
    wr(2'd1, 8'd3);
    wr(2'd0, 8'h01);
    repeat (8) @(posedge clk);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h01);
    waitRst(200, n); chk("R9 full timeout after re-enable", 8'(n), 8'd12);

    // R10 writes during pulse ignored
    por(1'b1);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd1);
    wr(2'd0, 8'h01);
    waitRst(50, n); chk("R4 count=1 timeout clocks", 8'(n), 8'd4);
    wr(2'd1, 8'd7);
    wr(2'd0, 8'h00);
    pulseWidth(w);
    rd(2'd1, d); chk("R10 count write in pulse", d, 8'd10);
    rd(2'd0, d); chk("R10 ctrl write in pulse", d, 8'h01);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule